// File: doc/BRIEF.md
# Inter-Frame Spacing Enforcer

This block sits between a host start request and the transmit sequencer and makes sure that consecutive frames are separated by at least a programmed number of preamble symbol periods. When the sequencer reports that the last data symbol of a frame has left, the block captures the 8-bit spacing setting and starts a countdown. That countdown acts as a post-amble of the frame just sent. The countdown advances only on the symbol-tick strobe.

The loaded gap is always the setting plus a fixed 6 symbols. A setting of 34 therefore holds off the next frame for 40 symbol periods. A host start request that arrives while the gap runs is kept as pending. It turns into a one-clock start grant on the first symbol tick after the gap has run out. The gap is only a minimum: no grant is ever issued unless a request has been made. The block also raises a one-clock end-of-frame event and a busy flag that covers the gap.

Top module: `ifs_gap_enforcer`

## Requirements
- R1: After reset, busy, start_grant and eof_evt are low and no request is pending, so a symbol tick with no request produces no grant.
- R2: A data_done pulse causes eof_evt to be high for exactly the one clock cycle that follows it.
- R3: busy rises in the cycle after data_done. The countdown advances only on clock cycles with sym_tick high. busy falls in the cycle after the (setting + 6)-th tick counted after data_done.
- R4: A start_req made while busy is high is held. start_grant is high for one cycle, in the cycle after the first sym_tick seen while busy is already low. start_grant is never high while busy is high.
- R5: A start_req made while idle is also held until a tick. start_grant rises in the cycle after the next sym_tick, and not before that tick.
- R6: The spacing setting is captured only in the data_done cycle. Changing gap_cfg during a gap does not change that gap's length.
- R7: A setting of 0 still enforces a 6-tick gap. A setting of 255 gives a 261-tick gap.
- R8: No start_grant is issued without a prior start_req. Each request is consumed by one grant.
- R9: A data_done during a running gap restarts the countdown from the current setting plus 6. A data_done in the same cycle as a qualifying tick suppresses that grant and keeps the request pending.
- R10: Asserting rst_n low in the middle of a gap clears busy at once. It also discards the pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_tick | input | 1 | One-clock strobe per preamble symbol period |
| data_done | input | 1 | One-clock pulse after the last data symbol of a frame |
| start_req | input | 1 | Host request to start a new frame |
| gap_cfg | input | 8 | Spacing setting in symbol periods, before the fixed 6 are added |
| start_grant | output | 1 | One-clock grant to the transmit sequencer |
| busy | output | 1 | High while the gap countdown is running |
| eof_evt | output | 1 | One-clock end-of-frame event |

## Verification
A corrupted countdown shows up as busy falling on the wrong tick. The error is therefore visible at the end of the gap, at most 261 ticks after data_done. A lost or stuck pending flag shows up at the first tick after the gap: the grant is either missing or issued without a request. A wrong capture of the setting shows up as a gap whose length follows a value written during the gap. The directed scenarios probe each of these at the exact tick where a difference first becomes visible.

// File: rtl/ifs_gap_pkg.sv
package ifs_gap_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned EXTRA_SYM = 6;
  localparam int unsigned CNT_MAX   = (1 << CFG_W) - 1 + EXTRA_SYM;
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
  typedef logic [CNT_W-1:0] gap_cnt_t;
endpackage

// File: rtl/ifs_rst_sync.sv
module ifs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/ifs_gap_counter.sv
module ifs_gap_counter
  import ifs_gap_pkg::*;
#(
  parameter int unsigned W_CFG = CFG_W,
  parameter int unsigned EXTRA = EXTRA_SYM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_tick,
  input  logic             load,
  input  logic [W_CFG-1:0] cfg,
  output logic             zero,
  output logic             eof_pulse
);
  localparam int unsigned LOCAL_MAX = (1 << W_CFG) - 1 + EXTRA;
  localparam int unsigned LOCAL_W   = $clog2(LOCAL_MAX + 1);

  logic [LOCAL_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;
  logic               eof_q;

  always_comb begin
    cnt_en = load | (sym_tick & (cnt_q != '0));
    if (load) cnt_d = LOCAL_W'(cfg) + LOCAL_W'(EXTRA);
    else      cnt_d = cnt_q - LOCAL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      eof_q <= 1'b0;
    end else begin
      eof_q <= load;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign zero      = (cnt_q == '0);
  assign eof_pulse = eof_q;
endmodule

// File: rtl/ifs_req_gate.sv
module ifs_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_tick,
  input  logic gap_zero,
  input  logic frame_end,
  input  logic start_req,
  output logic grant
);
  logic pend_q, pend_d;
  logic grant_q, fire;
  logic want;

  always_comb begin
    want   = pend_q | start_req;
    fire   = sym_tick & gap_zero & ~frame_end & want;
    pend_d = want & ~fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      grant_q <= fire;
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/ifs_gap_enforcer.sv
module ifs_gap_enforcer
  import ifs_gap_pkg::*;
#(
  parameter int unsigned GAP_CFG_W = CFG_W,
  parameter int unsigned GAP_EXTRA = EXTRA_SYM,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_tick,
  input  logic                 data_done,
  input  logic                 start_req,
  input  logic [GAP_CFG_W-1:0] gap_cfg,
  output logic                 start_grant,
  output logic                 busy,
  output logic                 eof_evt
);
  logic rst_sync_n;
  logic gap_zero;

  ifs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  ifs_gap_counter #(.W_CFG(GAP_CFG_W), .EXTRA(GAP_EXTRA)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sym_tick  (sym_tick),
    .load      (data_done),
    .cfg       (gap_cfg),
    .zero      (gap_zero),
    .eof_pulse (eof_evt)
  );

  ifs_req_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sym_tick  (sym_tick),
    .gap_zero  (gap_zero),
    .frame_end (data_done),
    .start_req (start_req),
    .grant     (start_grant)
  );

  assign busy = ~gap_zero;
endmodule

// File: rtl/ifs_gap_checker.sv
module ifs_gap_checker (
  input logic clk,
  input logic rst_n,
  input logic sym_tick,
  input logic data_done,
  input logic start_req,
  input logic start_grant,
  input logic busy,
  input logic eof_evt
);
  logic req_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           req_seen_q <= 1'b0;
    else if (start_grant) req_seen_q <= start_req;
    else                  req_seen_q <= req_seen_q | start_req;
  end

  AST_EOF_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n) data_done |=> eof_evt); // R2
  AST_EOF_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) eof_evt |-> $past(data_done)); // R2
  AST_BUSY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) data_done |=> busy); // R3
  AST_BUSY_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(sym_tick)); // R3
  AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start_grant |-> !busy); // R4
  AST_GRANT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) start_grant |-> $past(sym_tick)); // R5
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) start_grant |-> req_seen_q); // R8
  AST_DONE_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) data_done |=> !start_grant); // R9
endmodule

bind ifs_gap_enforcer ifs_gap_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sym_tick    (sym_tick),
  .data_done   (data_done),
  .start_req   (start_req),
  .start_grant (start_grant),
  .busy        (busy),
  .eof_evt     (eof_evt)
);

// File: tb/ifs_gap_enforcer_test.sv
module ifs_gap_enforcer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_tick = 1'b0;
  logic       data_done = 1'b0;
  logic       start_req = 1'b0;
  logic [7:0] gap_cfg = 8'd0;
  logic       start_grant, busy, eof_evt;
  int         checks = 0;
  int         failures = 0;

  always #10 clk = ~clk;

  ifs_gap_enforcer uut (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .data_done(data_done),
    .start_req(start_req), .gap_cfg(gap_cfg), .start_grant(start_grant),
    .busy(busy), .eof_evt(eof_evt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sym_tick = 0; data_done = 0; start_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    sym_tick = 1'b1; @(negedge clk); sym_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick(); @(negedge clk); end
  endtask

  task automatic done();
    data_done = 1'b1; @(negedge clk); data_done = 1'b0;
  endtask

  task automatic req();
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 busy", busy, 1'b0);
    check("R1 grant", start_grant, 1'b0);
    check("R1 eof", eof_evt, 1'b0);
    tick();
    check("R1 no pending", start_grant, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_gap34();
    do_reset();
    gap_cfg = 8'd34;
    done();
    check("R2 eof high", eof_evt, 1'b1);
    check("R3 busy rise", busy, 1'b1);
    @(negedge clk);
    check("R2 eof one cycle", eof_evt, 1'b0);
    req();
    gap_cfg = 8'd2;
    ticks(20);
    repeat (25) @(negedge clk);
    check("R3 no tick no count", busy, 1'b1);
    ticks(19);
    check("R6 busy before 40th", busy, 1'b1);
    check("R4 no grant in gap", start_grant, 1'b0);
    tick();
    check("R3 busy falls after 40th", busy, 1'b0);
    check("R4 no grant on 40th", start_grant, 1'b0);
    @(negedge clk);
    tick();
    check("R4 grant after 41st", start_grant, 1'b1);
    @(negedge clk);
    check("R4 grant one cycle", start_grant, 1'b0);
    tick();
    check("R8 consumed", start_grant, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_idle();
    do_reset();
    req();
    repeat (5) @(negedge clk);
    check("R5 no grant without tick", start_grant, 1'b0);
    tick();
    check("R5 grant after tick", start_grant, 1'b1);
    @(negedge clk);
    check("R5 grant one cycle", start_grant, 1'b0);
  endtask

  task automatic t_extremes();
    do_reset();
    gap_cfg = 8'd0;
    done(); @(negedge clk);
    ticks(5);
    check("R7 cfg0 busy at 5", busy, 1'b1);
    tick();
    check("R7 cfg0 idle at 6", busy, 1'b0);
    @(negedge clk);
    gap_cfg = 8'd255;
    done(); @(negedge clk);
    ticks(260);
    check("R7 cfg255 busy at 260", busy, 1'b1);
    tick();
    check("R7 cfg255 idle at 261", busy, 1'b0);
    @(negedge clk);
    tick();
    check("R8 no request no grant", start_grant, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_restart();
    do_reset();
    gap_cfg = 8'd10;
    done(); @(negedge clk);
    ticks(5);
    gap_cfg = 8'd3;
    done(); @(negedge clk);
    ticks(8);
    check("R9 restart busy at 8", busy, 1'b1);
    tick();
    check("R9 restart idle at 9", busy, 1'b0);
    @(negedge clk);
    req();
    gap_cfg = 8'd0;
    sym_tick = 1'b1; data_done = 1'b1;
    @(negedge clk);
    sym_tick = 1'b0; data_done = 1'b0;
    check("R9 grant suppressed", start_grant, 1'b0);
    check("R9 busy again", busy, 1'b1);
    @(negedge clk);
    ticks(6);
    tick();
    check("R9 pending kept", start_grant, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_mid_reset();
    do_reset();
    gap_cfg = 8'd20;
    done(); @(negedge clk);
    req();
    ticks(3);
    rst_n = 1'b0;
    #1;
    check("R10 busy cleared", busy, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tick();
    check("R10 pending cleared", start_grant, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_gap34();
    t_idle();
    t_extremes();
    t_restart();
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule